// File: doc/BRIEF.md
# Four-Channel PWM Generator with Pair Concatenation

This block generates four pulse-width-modulated waveforms. Each channel owns an up-counter, a period register and a duty register, all one byte wide. A channel's counter advances only in cycles where its count enable input is high. These enables come from a prescaler that sits outside the block. The counter runs from zero up to the period value and then wraps. The waveform is active while the counter is below the duty value.

A control register holds two join bits. Each join bit fuses two neighbouring channels into one channel twice as wide, and the bits can change at run time. In a joined pair:

- The even channel holds the high byte and the odd channel holds the low byte.
- The pair counts on the odd channel's enable.
- The waveform appears on the odd channel's pin.
- The even channel's output enable drops, so that pin can be reused for general-purpose I/O.

All registers sit on a byte-wide bus with a combinational read path. Reading the high counter byte of a joined pair captures the low byte for the following cycle. This lets software read a coherent two-byte value. Counter writes never load data; they only clear the counter.

Top module: `pwm_quad`

## Requirements
- R1: After reset, all counters, periods, duties and both join bits are zero. All four `pwm_out` are 0 and all four `pwm_oe` are 1.
- R2: In an unjoined channel i, a cycle with `cnt_en[i]` high advances the counter by one. If the counter equals the period, that cycle wraps it to 0 instead, giving a period of (period+1) enabled cycles. A counter above the period climbs to 255 and wraps to 0.
- R3: An unjoined channel drives `pwm_out[i]` = 1 exactly while counter < duty. A duty of 0 keeps the output low, and a duty above the period keeps it high.
- R4: Control register bit 0 joins channels 0 (high byte) and 1 (low byte); bit 1 joins channels 2 (high) and 3 (low). A joined pair compares its 16-bit counter with the 16-bit period and advances only on the low channel's enable (`cnt_en[1]` or `cnt_en[3]`).
- R5: In a joined pair, the low channel's `pwm_out` is 1 exactly while the 16-bit counter < the 16-bit duty. The high channel has `pwm_oe` = 0 and `pwm_out` = 0, and `pwm_oe` of the low channel stays 1.
- R6: A read of a joined pair's high counter byte captures the current low byte. A read of that pair's low counter byte in the very next cycle returns the captured value. Any other low-byte read returns the live counter.
- R7: In a joined pair, writing the low counter byte clears both bytes, and writing the high counter byte leaves the counter unchanged.
- R8: In an unjoined channel, any write to its counter clears it to 0, and the write takes priority over a count enable in the same cycle.
- R9: Written period, duty and control values take effect from the cycle after the write, including on a running counter.
- R10: Addresses: 0 = control (join bits in [1:0], upper bits read 0); 1–4 = counters of channels 0–3; 5–8 = periods; 9–12 = duties; 13–15 read 0. `bus_rdata` is 0 when `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read cycle |
| cnt_en | input | 4 | Per-channel prescaled count enables |
| pwm_out | output | 4 | Waveform outputs |
| pwm_oe | output | 4 | Output-enable flags, 0 releases the pin |

## Verification
The timing of each result:

- Register and counter writes, count enables and join changes act at the next rising edge. The waveform outputs are combinational from that state, so they show the change one cycle after the stimulus.
- Read data is combinational and belongs to the cycle in which `bus_rd` is high.
- The captured low byte is visible only in the cycle right after the high-byte read.

The bench drives each stimulus at a falling edge. It compares outputs and read data against a behavioural model a short settle delay later, which is before the next rising edge. It then advances the model by exactly one edge, so every comparison lines up with the cycle in which the result is due.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;

    localparam int CH_N   = 4;
    localparam int PAIR_N = CH_N / 2;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;
    localparam int CH_IW  = $clog2(CH_N);

    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_CNT  = 4'd1;
    localparam logic [ADDR_W-1:0] A_PER  = 4'd5;
    localparam logic [ADDR_W-1:0] A_DUTY = 4'd9;
    localparam logic [ADDR_W-1:0] A_END  = 4'd13;

    typedef enum logic [1:0] {
        FLD_CNT,
        FLD_PER,
        FLD_DUTY,
        FLD_NONE
    } fld_e;

    typedef enum logic {
        PAIR_SPLIT,
        PAIR_JOINED
    } pair_mode_e;

    typedef struct packed {
        logic             is_ctrl;
        fld_e             fld;
        logic [CH_IW-1:0] ch;
    } dec_t;

    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.is_ctrl = (a == A_CTRL);
        d.fld     = FLD_NONE;
        d.ch      = '0;
        if (a >= A_CNT && a < A_PER) begin
            d.fld = FLD_CNT;
            d.ch  = CH_IW'(a - A_CNT);
        end else if (a >= A_PER && a < A_DUTY) begin
            d.fld = FLD_PER;
            d.ch  = CH_IW'(a - A_PER);
        end else if (a >= A_DUTY && a < A_END) begin
            d.fld = FLD_DUTY;
            d.ch  = CH_IW'(a - A_DUTY);
        end
        return d;
    endfunction

    // high-order channel of a pair is the even one
    function automatic logic is_high_ch(input logic [CH_IW-1:0] ch);
        return ~ch[0];
    endfunction

endpackage

// File: rtl/pwmq_regs.sv
module pwmq_regs
    import pwmq_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic                 rd,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DW-1:0]        wdata,
    input  logic [CH_N*DW-1:0]   cnt_flat,
    output logic [DW-1:0]        rdata,
    output logic [PAIR_N-1:0]    join_q,
    output logic [CH_N*DW-1:0]   per_flat,
    output logic [CH_N*DW-1:0]   duty_flat,
    output logic [CH_N-1:0]      cnt_wr
);

    dec_t dec;
    assign dec = decode_addr(addr);

    logic [DW-1:0] per_q  [CH_N];
    logic [DW-1:0] duty_q [CH_N];
    logic [DW-1:0] cnt_arr[CH_N];

    for (genvar k = 0; k < CH_N; k++) begin : g_flat
        assign cnt_arr[k]             = cnt_flat[k*DW +: DW];
        assign per_flat[k*DW +: DW]   = per_q[k];
        assign duty_flat[k*DW +: DW]  = duty_q[k];
        assign cnt_wr[k]              = wr && (dec.fld == FLD_CNT) && (dec.ch == CH_IW'(k));
    end

    // coherent wide read: capture low byte when the high byte is read
    logic          snap_v;
    logic          snap_pair;
    logic [DW-1:0] snap_val;
    logic          snap_take;
    logic          pair_sel;

    assign pair_sel  = dec.ch[CH_IW-1];
    assign snap_take = rd && (dec.fld == FLD_CNT) && is_high_ch(dec.ch) && join_q[pair_sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            join_q    <= '0;
            snap_v    <= 1'b0;
            snap_pair <= 1'b0;
            snap_val  <= '0;
            for (int k = 0; k < CH_N; k++) begin
                per_q[k]  <= '0;
                duty_q[k] <= '0;
            end
        end else begin
            if (wr && dec.is_ctrl) begin
                join_q <= wdata[PAIR_N-1:0];
            end
            if (wr && dec.fld == FLD_PER) begin
                per_q[dec.ch] <= wdata;
            end
            if (wr && dec.fld == FLD_DUTY) begin
                duty_q[dec.ch] <= wdata;
            end
            snap_v <= snap_take;
            if (snap_take) begin
                snap_pair <= pair_sel;
                snap_val  <= cnt_arr[{pair_sel, 1'b1}];
            end
        end
    end

    logic use_snap;
    assign use_snap = snap_v && !is_high_ch(dec.ch) && (snap_pair == pair_sel)
                      && join_q[pair_sel];

    always_comb begin
        rdata = '0;
        if (rd) begin
            if (dec.is_ctrl) begin
                rdata = DW'(join_q);
            end else begin
                unique case (dec.fld)
                    FLD_CNT:  rdata = use_snap ? snap_val : cnt_arr[dec.ch];
                    FLD_PER:  rdata = per_q[dec.ch];
                    FLD_DUTY: rdata = duty_q[dec.ch];
                    default:  rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/pwmq_pair.sv
module pwmq_pair
    import pwmq_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          join_en,
    input  logic [1:0]    en,
    input  logic [1:0]    clr,
    input  logic [DW-1:0] per_hi,
    input  logic [DW-1:0] per_lo,
    input  logic [DW-1:0] duty_hi,
    input  logic [DW-1:0] duty_lo,
    output logic [DW-1:0] cnt_hi,
    output logic [DW-1:0] cnt_lo,
    output logic          out_hi,
    output logic          out_lo,
    output logic          oe_hi,
    output logic          oe_lo
);

    localparam int WW = 2 * DW;

    pair_mode_e mode;
    assign mode = join_en ? PAIR_JOINED : PAIR_SPLIT;

    // lane 0 = high-order channel, lane 1 = low-order channel
    logic [DW-1:0] lane_q   [2];
    logic [DW-1:0] lane_per [2];
    logic [DW-1:0] lane_duty[2];
    logic [DW-1:0] lane_nxt [2];
    logic          lane_hit [2];

    assign lane_per[0]  = per_hi;
    assign lane_per[1]  = per_lo;
    assign lane_duty[0] = duty_hi;
    assign lane_duty[1] = duty_lo;

    for (genvar k = 0; k < 2; k++) begin : g_lane
        assign lane_nxt[k] = (lane_q[k] == lane_per[k]) ? '0 : lane_q[k] + 1'b1;
        assign lane_hit[k] = lane_q[k] < lane_duty[k];
    end

    logic [WW-1:0] wide_cnt, wide_per, wide_duty, wide_nxt;
    logic          wide_hit;

    assign wide_cnt  = {lane_q[0], lane_q[1]};
    assign wide_per  = {per_hi, per_lo};
    assign wide_duty = {duty_hi, duty_lo};
    assign wide_nxt  = (wide_cnt == wide_per) ? '0 : wide_cnt + 1'b1;
    assign wide_hit  = wide_cnt < wide_duty;

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q[0] <= '0;
            lane_q[1] <= '0;
        end else if (mode == PAIR_JOINED) begin
            if (clr[1]) begin
                lane_q[0] <= '0;
                lane_q[1] <= '0;
            end else if (en[1]) begin
                lane_q[0] <= wide_nxt[WW-1:DW];
                lane_q[1] <= wide_nxt[DW-1:0];
            end
        end else begin
            for (int k = 0; k < 2; k++) begin
                if (clr[k]) begin
                    lane_q[k] <= '0;
                end else if (en[k]) begin
                    lane_q[k] <= lane_nxt[k];
                end
            end
        end
    end

    assign cnt_hi = lane_q[0];
    assign cnt_lo = lane_q[1];
    assign out_hi = (mode == PAIR_JOINED) ? 1'b0 : lane_hit[0];
    assign out_lo = (mode == PAIR_JOINED) ? wide_hit : lane_hit[1];
    assign oe_hi  = (mode == PAIR_SPLIT);
    assign oe_lo  = 1'b1;

endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
    import pwmq_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [CH_N-1:0]   cnt_en,
    output logic [CH_N-1:0]   pwm_out,
    output logic [CH_N-1:0]   pwm_oe
);

    logic [PAIR_N-1:0]  join_q;
    logic [CH_N*DW-1:0] cnt_flat;
    logic [CH_N*DW-1:0] per_flat;
    logic [CH_N*DW-1:0] duty_flat;
    logic [CH_N-1:0]    cnt_wr;

    pwmq_regs #(.DW(DW)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .cnt_flat (cnt_flat),
        .rdata    (bus_rdata),
        .join_q   (join_q),
        .per_flat (per_flat),
        .duty_flat(duty_flat),
        .cnt_wr   (cnt_wr)
    );

    for (genvar p = 0; p < PAIR_N; p++) begin : g_pair
        localparam int HI = 2 * p;
        localparam int LO = 2 * p + 1;

        pwmq_pair #(.DW(DW)) pair_i (
            .clk    (clk),
            .rst    (rst),
            .join_en(join_q[p]),
            .en     (cnt_en[HI +: 2]),
            .clr    (cnt_wr[HI +: 2]),
            .per_hi (per_flat[HI*DW +: DW]),
            .per_lo (per_flat[LO*DW +: DW]),
            .duty_hi(duty_flat[HI*DW +: DW]),
            .duty_lo(duty_flat[LO*DW +: DW]),
            .cnt_hi (cnt_flat[HI*DW +: DW]),
            .cnt_lo (cnt_flat[LO*DW +: DW]),
            .out_hi (pwm_out[HI]),
            .out_lo (pwm_out[LO]),
            .oe_hi  (pwm_oe[HI]),
            .oe_lo  (pwm_oe[LO])
        );
    end

endmodule

// File: rtl/pwmq_chk.sv
module pwmq_chk
    import pwmq_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CH_N-1:0]   cnt_en,
    input logic [CH_N-1:0]   pwm_out,
    input logic [CH_N-1:0]   pwm_oe,
    input logic [PAIR_N-1:0] join_q,
    input logic [CH_N*DW-1:0] cnt_flat,
    input logic [CH_N*DW-1:0] per_flat
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pwm_out == '0 && pwm_oe == '1));

    for (genvar p = 0; p < PAIR_N; p++) begin : g_pair_chk
        localparam int HI = 2 * p;
        localparam int LO = 2 * p + 1;

        // R5
        hi_pin_released_chk: assert property (@(posedge clk) disable iff (rst)
            join_q[p] |-> (!pwm_oe[HI] && !pwm_out[HI] && pwm_oe[LO]));

        // R7
        lo_write_clears_pair_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == A_CNT + ADDR_W'(LO) && join_q[p])
            |=> (cnt_flat[HI*DW +: DW] == '0 && cnt_flat[LO*DW +: DW] == '0));

        // R7
        hi_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == A_CNT + ADDR_W'(HI) && join_q[p] && !cnt_en[LO])
            |=> ($stable(cnt_flat[HI*DW +: DW]) && $stable(cnt_flat[LO*DW +: DW])));
    end

    for (genvar k = 0; k < CH_N; k++) begin : g_ch_chk
        // R8
        split_write_clears_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == A_CNT + ADDR_W'(k) && !join_q[k/2])
            |=> (cnt_flat[k*DW +: DW] == '0));

        // R2
        split_step_chk: assert property (@(posedge clk) disable iff (rst)
            (!join_q[k/2] && cnt_en[k] && !(bus_wr && bus_addr == A_CNT + ADDR_W'(k))
             && cnt_flat[k*DW +: DW] != per_flat[k*DW +: DW])
            |=> (cnt_flat[k*DW +: DW] == DW'($past(cnt_flat[k*DW +: DW]) + 1'b1)));
    end

endmodule

bind pwm_quad pwmq_chk #(.DW(DW)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .cnt_en  (cnt_en),
    .pwm_out (pwm_out),
    .pwm_oe  (pwm_oe),
    .join_q  (join_q),
    .cnt_flat(cnt_flat),
    .per_flat(per_flat)
);

// File: tb/pwm_quad_tb_top.sv
module pwm_quad_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] cnt_en = '0;
    logic [3:0] pwm_out;
    logic [3:0] pwm_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_quad dut_i (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cnt_en   (cnt_en),
        .pwm_out  (pwm_out),
        .pwm_oe   (pwm_oe)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // behavioural reference state
    int m_cnt[4];
    int m_per[4];
    int m_duty[4];
    int m_join;
    int snap_v, snap_pair, snap_val;
    int en_mode;
    logic [15:0] lfsr = 16'hACE1;
    string rd_req = "R10";

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int wide(int p, int which);
        // which: 0 counter, 1 period, 2 duty
        if (which == 0) return m_cnt[2*p] * 256 + m_cnt[2*p+1];
        if (which == 1) return m_per[2*p] * 256 + m_per[2*p+1];
        return m_duty[2*p] * 256 + m_duty[2*p+1];
    endfunction

    function automatic int exp_read(int a);
        int ch;
        if (a == 0) return m_join;
        if (a >= 1 && a <= 4) begin
            ch = a - 1;
            if ((ch % 2) == 1 && snap_v != 0 && snap_pair == ch / 2 && ((m_join >> (ch / 2)) & 1) != 0)
                return snap_val;
            return m_cnt[ch];
        end
        if (a >= 5 && a <= 8) return m_per[a - 5];
        if (a >= 9 && a <= 12) return m_duty[a - 9];
        return 0;
    endfunction

    task automatic compare_ports();
        for (int c = 0; c < 4; c++) begin
            int p, eo, eoe;
            bit j;
            p = c / 2;
            j = ((m_join >> p) & 1) != 0;
            if (j) begin
                eoe = c % 2;
                eo  = ((c % 2) == 1) ? int'(wide(p, 0) < wide(p, 2)) : 0;
                check("R5", $sformatf("pwm_out[%0d] joined", c), int'(pwm_out[c]), eo);
            end else begin
                eoe = 1;
                eo  = int'(m_cnt[c] < m_duty[c]);
                check("R3", $sformatf("pwm_out[%0d]", c), int'(pwm_out[c]), eo);
            end
            check("R5", $sformatf("pwm_oe[%0d]", c), int'(pwm_oe[c]), eoe);
        end
        if (bus_rd)
            check(rd_req, $sformatf("read addr %0d", bus_addr), int'(bus_rdata), exp_read(int'(bus_addr)));
        else
            check("R10", "idle rdata", int'(bus_rdata), 0);
    endtask

    task automatic model_update();
        int a, ojoin;
        a     = int'(bus_addr);
        ojoin = m_join;
        // capture for coherent read uses pre-edge counter
        if (bus_rd && (a == 1 || a == 3) && ((ojoin >> ((a - 1) / 2)) & 1) != 0) begin
            snap_v    = 1;
            snap_pair = (a - 1) / 2;
            snap_val  = m_cnt[a];
        end else begin
            snap_v = 0;
        end
        for (int p = 0; p < 2; p++) begin
            int hi, lo, v;
            bit wh, wl;
            hi = 2 * p;
            lo = 2 * p + 1;
            wh = bus_wr && a == 1 + hi;
            wl = bus_wr && a == 1 + lo;
            if (((ojoin >> p) & 1) != 0) begin
                if (wl) begin
                    m_cnt[hi] = 0;
                    m_cnt[lo] = 0;
                end else if (cnt_en[lo]) begin
                    v = wide(p, 0);
                    v = (v == wide(p, 1)) ? 0 : (v + 1) % 65536;
                    m_cnt[hi] = v / 256;
                    m_cnt[lo] = v % 256;
                end
            end else begin
                if (wh) m_cnt[hi] = 0;
                else if (cnt_en[hi]) m_cnt[hi] = (m_cnt[hi] == m_per[hi]) ? 0 : (m_cnt[hi] + 1) % 256;
                if (wl) m_cnt[lo] = 0;
                else if (cnt_en[lo]) m_cnt[lo] = (m_cnt[lo] == m_per[lo]) ? 0 : (m_cnt[lo] + 1) % 256;
            end
        end
        if (bus_wr) begin
            if (a == 0) m_join = int'(bus_wdata) & 3;
            else if (a >= 5 && a <= 8) m_per[a - 5] = int'(bus_wdata);
            else if (a >= 9 && a <= 12) m_duty[a - 9] = int'(bus_wdata);
        end
    endtask

    task automatic step();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (en_mode)
            0: cnt_en = 4'b0000;
            1: cnt_en = 4'b1111;
            default: cnt_en = lfsr[3:0];
        endcase
        #1;
        compare_ports();
        model_update();
        @(negedge clk);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic bus_write(int a, int d);
        bus_wr = 1'b1;
        bus_addr = 4'(a);
        bus_wdata = 8'(d);
        step();
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(int a, string req);
        rd_req = req;
        bus_rd = 1'b1;
        bus_addr = 4'(a);
        step();
        bus_rd = 1'b0;
        rd_req = "R10";
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 4; k++) begin
            m_cnt[k] = 0; m_per[k] = 0; m_duty[k] = 0;
        end
        m_join = 0; snap_v = 0; snap_pair = 0; snap_val = 0; en_mode = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every register and pin
        for (int a = 0; a < 16; a++) bus_read(a, "R1");
        run(3);

        // R9, R3: split channels with varied duty relations
        bus_write(5, 4);   bus_write(9, 2);
        bus_write(6, 9);   bus_write(10, 0);
        bus_write(7, 3);   bus_write(11, 7);
        bus_write(8, 255); bus_write(12, 128);
        en_mode = 1; run(40);
        // R2: sparse enables
        en_mode = 2; run(300);
        for (int a = 1; a <= 4; a++) bus_read(a, "R2");

        // R8: counter write clears and beats a same-cycle enable
        en_mode = 1;
        run(5);
        bus_write(2, 200);
        bus_read(2, "R8");
        bus_write(4, 17);
        bus_read(4, "R8");

        // R9, R2: period lowered under a running counter wraps through 255
        run(50);
        bus_write(8, 5);
        run(300);
        bus_write(9, 1);
        run(20);

        // R4, R5: join channels 0/1
        bus_write(0, 1);
        bus_read(0, "R10");
        bus_write(5, 1);  bus_write(6, 8'h20);
        bus_write(9, 0);  bus_write(10, 8'h90);
        bus_write(2, 0);
        run(700);
        en_mode = 2; run(600);

        // R6: coherent read while the counter runs
        en_mode = 1;
        bus_read(1, "R6");
        bus_read(2, "R6");
        run(3);
        bus_read(2, "R6");
        bus_read(1, "R6");
        run(1);
        bus_read(2, "R6");

        // R7: high write ignored, low write clears pair
        en_mode = 0;
        bus_write(1, 8'h55);
        bus_read(1, "R7");
        bus_read(2, "R7");
        bus_write(2, 8'h33);
        bus_read(1, "R7");
        bus_read(2, "R7");
        en_mode = 1; run(100);

        // R4: join channels 2/3 too
        bus_write(7, 0);  bus_write(8, 8'h30);
        bus_write(11, 0); bus_write(12, 8'h10);
        bus_write(0, 3);
        bus_write(4, 0);
        run(400);
        bus_read(3, "R6");
        bus_read(4, "R6");

        // R9: unjoin pair 2/3 at run time
        bus_write(0, 1);
        en_mode = 2; run(300);

        // R5: 16-bit duty above period keeps output high
        bus_write(9, 8'hFF);
        en_mode = 1; run(300);
        for (int a = 0; a < 13; a++) bus_read(a, "R10");

        finish_run();
    end

endmodule